// File: doc/BRIEF.md
# Single-Wire Pulse-Count Register Port

This block sits behind one control pin that does two jobs. Held high, the pin keeps the device awake. Toggled, it carries register writes. While the device is awake, each low-then-high pulse on the pin adds one to a word counter. When the pin then stays high long enough, the count is closed off as one word. The first word of a pair picks a control register and the second word is the value written there. If the pin is held low for a long time, the device drops into shutdown and every register returns to its default value.

The same block also owns the flash request. Each of two flash trigger inputs can start flash mode with a rising edge. Flash mode stops only when both inputs are low, and at that moment the flash level register is cleared. All three inputs pass through two-flop synchronizers before any decoding.

The register values, the awake flag, the flash state and a one-cycle write strobe are outputs. The analog circuits that use them are outside this block.

Top module: `pulse_word_ctrl`

## Requirements
- R1: After reset the block is disabled (`dev_en_o`=0) and the registers hold their defaults. The first rising edge on the line sets `dev_en_o` to 1, and that edge is not counted as a pulse.
- R2: While enabled, each rising edge of the synchronized line adds one to the word count, so the word value equals the number of pulses.
- R3: A word closes once the line has stayed high for `GAP_CYC` cycles after its last rising edge. A low period shorter than `SHDN_CYC` does not close or split a word.
- R4: The word count saturates at 2^`CNT_W`-1. It never wraps.
- R5: Words pair up in order: address first, then data. Address 1 selects flash level, 2 torch level, 3 timer duration, 4 timer current and 5 low-battery threshold. The data word is written to the selected register.
- R6: An address word above 5 consumes its data word. No register changes and no strobe is issued.
- R7: `wr_stb_o` is high for exactly one cycle for each committed write.
- R8: If the line is low for `SHDN_CYC` cycles, `dev_en_o` drops to 0 and all registers return to their defaults (flash 0, torch 0, duration 6, current 4, low-battery 3). A half-received pair is also dropped.
- R9: A rising edge on either `fen_a_i` or `fen_b_i` sets `flash_on_o`.
- R10: While flash is on, it stays on as long as either trigger is high. When both triggers are low, `flash_on_o` clears and the flash level register is cleared with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dc_line_i | input | 1 | Combined enable / pulse-count line (asynchronous) |
| fen_a_i | input | 1 | Flash trigger A (asynchronous) |
| fen_b_i | input | 1 | Flash trigger B (asynchronous) |
| dev_en_o | output | 1 | Device awake |
| flash_on_o | output | 1 | Flash mode active |
| wr_stb_o | output | 1 | One-cycle pulse per committed write |
| flash_lvl_o | output | CNT_W | Flash level register |
| torch_lvl_o | output | CNT_W | Torch level register |
| tmr_dur_o | output | CNT_W | Safety timer duration register |
| tmr_cur_o | output | CNT_W | Safety timer current threshold register |
| lowbat_o | output | CNT_W | Low-battery threshold register |

## Verification
The bench builds the block with `CNT_W`=4, `GAP_CYC`=16 and `SHDN_CYC`=200. The 4-bit count lets a 20-pulse data word show saturation at 15. A 200-cycle shutdown window lets the bench hold a 100-cycle low that must not shut down, and a full shutdown with register restore, in a few hundred cycles. With these values, address 7 is still representable, so the discard path for out-of-range addresses can be reached alongside all five valid addresses.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

    localparam int NUM_REGS = 5;

    typedef enum logic [2:0] {
        IDX_FLASH  = 3'd0,
        IDX_TORCH  = 3'd1,
        IDX_TDUR   = 3'd2,
        IDX_TCUR   = 3'd3,
        IDX_LOWBAT = 3'd4
    } reg_idx_e;

    // Level and rising-edge view of one synchronized input
    typedef struct packed {
        logic lvl;
        logic rise;
    } edge_t;

    // Power-up / shutdown value of each control register
    function automatic int reg_default(input int idx);
        case (idx)
            int'(IDX_TDUR):   return 6;
            int'(IDX_TCUR):   return 4;
            int'(IDX_LOWBAT): return 3;
            default:          return 0;
        endcase
    endfunction

endpackage

// File: rtl/pwc_sync.sv
module pwc_sync
    import pwc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  d,
    output edge_t q
);
    logic [STAGES-1:0] sh;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            prev <= 1'b0;
        end else begin
            sh   <= {sh[STAGES-2:0], d};
            prev <= sh[STAGES-1];
        end
    end

    assign q.lvl  = sh[STAGES-1];
    assign q.rise = sh[STAGES-1] & ~prev;

endmodule

// File: rtl/pwc_framer.sv
module pwc_framer
    import pwc_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter int GAP_CYC  = 64,
    parameter int SHDN_CYC = 4096
) (
    input  logic             clk,
    input  logic             rst,
    input  edge_t            line,
    output logic             dev_en,
    output logic             shdn,
    output logic             word_vld,
    output logic [CNT_W-1:0] word_val
);
    localparam int GW = $clog2(GAP_CYC + 1);
    localparam int SW = $clog2(SHDN_CYC + 1);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;
    logic [GW-1:0]    idle;
    logic [SW-1:0]    low;
    logic             gap_hit;
    logic             low_hit;

    assign gap_hit = dev_en && line.lvl && !line.rise
                     && (idle == GW'(GAP_CYC - 1)) && (cnt != '0);
    assign low_hit = dev_en && !line.lvl && (low == SW'(SHDN_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            dev_en   <= 1'b0;
            shdn     <= 1'b0;
            word_vld <= 1'b0;
            word_val <= '0;
            cnt      <= '0;
            idle     <= '0;
            low      <= '0;
        end else begin
            word_vld <= 1'b0;
            shdn     <= 1'b0;
            if (!dev_en) begin
                // Wake edge enables the device but is not counted
                cnt  <= '0;
                idle <= '0;
                low  <= '0;
                if (line.rise) dev_en <= 1'b1;
            end else begin
                if (line.rise)                                  idle <= '0;
                else if (line.lvl && idle != GW'(GAP_CYC))      idle <= idle + 1'b1;

                if (line.lvl)                                   low <= '0;
                else if (low != SW'(SHDN_CYC))                  low <= low + 1'b1;

                if (low_hit) begin
                    dev_en <= 1'b0;
                    shdn   <= 1'b1;
                    cnt    <= '0;
                end else if (line.rise) begin
                    if (cnt != CMAX) cnt <= cnt + 1'b1;
                end else if (gap_hit) begin
                    word_vld <= 1'b1;
                    word_val <= cnt;
                    cnt      <= '0;
                end
            end
        end
    end

    // R3: a closed word always carries at least one pulse
    p_word_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
        word_vld |-> (word_val != '0));

    // R8: the shutdown pulse coincides with the device being disabled
    p_shdn_disables_r8: assert property (@(posedge clk) disable iff (rst)
        shdn |-> !dev_en);

endmodule

// File: rtl/pwc_regfile.sv
module pwc_regfile
    import pwc_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               shdn,
    input  logic                               word_vld,
    input  logic [CNT_W-1:0]                   word_val,
    input  logic                               fen_lvl,
    input  logic                               fen_start,
    output logic [NUM_REGS-1:0][CNT_W-1:0]     regs,
    output logic                               flash_on,
    output logic                               wr_stb
);
    logic [NUM_REGS-1:0][CNT_W-1:0] dflt;
    logic                           pending;
    logic [CNT_W-1:0]               paddr;
    logic                           addr_ok;

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) dflt[i] = CNT_W'(reg_default(i));
    end

    assign addr_ok = (paddr != '0) && (paddr <= CNT_W'(NUM_REGS));

    always_ff @(posedge clk) begin
        if (rst) begin
            regs     <= dflt;
            pending  <= 1'b0;
            paddr    <= '0;
            flash_on <= 1'b0;
            wr_stb   <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            if (shdn) begin
                regs    <= dflt;
                pending <= 1'b0;
            end else if (word_vld) begin
                if (!pending) begin
                    pending <= 1'b1;
                    paddr   <= word_val;
                end else begin
                    pending <= 1'b0;
                    for (int i = 0; i < NUM_REGS; i++) begin
                        if (paddr == CNT_W'(i + 1)) regs[i] <= word_val;
                    end
                    if (addr_ok) wr_stb <= 1'b1;
                end
            end
            // Flash termination takes priority over a same-cycle write
            if (flash_on && !fen_lvl) begin
                flash_on        <= 1'b0;
                regs[IDX_FLASH] <= '0;
            end else if (fen_start) begin
                flash_on <= 1'b1;
            end
        end
    end

    // R7: the strobe never lasts two cycles
    p_stb_single_r7: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    // R7: a strobe only follows a closed word
    p_stb_after_word_r7: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> $past(word_vld));

    // R8: shutdown restores every register default
    p_shdn_defaults_r8: assert property (@(posedge clk) disable iff (rst)
        shdn |=> (regs == dflt));

    // R9: a trigger edge turns flash on
    p_flash_start_r9: assert property (@(posedge clk) disable iff (rst)
        fen_start |=> flash_on);

    // R10: both triggers low ends flash and clears its level
    p_flash_end_r10: assert property (@(posedge clk) disable iff (rst)
        (flash_on && !fen_lvl) |=> (!flash_on && regs[IDX_FLASH] == '0));

endmodule

// File: rtl/pulse_word_ctrl.sv
module pulse_word_ctrl
    import pwc_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter int GAP_CYC  = 64,
    parameter int SHDN_CYC = 4096
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dc_line_i,
    input  logic             fen_a_i,
    input  logic             fen_b_i,
    output logic             dev_en_o,
    output logic             flash_on_o,
    output logic             wr_stb_o,
    output logic [CNT_W-1:0] flash_lvl_o,
    output logic [CNT_W-1:0] torch_lvl_o,
    output logic [CNT_W-1:0] tmr_dur_o,
    output logic [CNT_W-1:0] tmr_cur_o,
    output logic [CNT_W-1:0] lowbat_o
);
    localparam int N_IN = 3;

    logic [N_IN-1:0] raw;
    edge_t           sig [N_IN];

    assign raw = {fen_b_i, fen_a_i, dc_line_i};

    for (genvar g = 0; g < N_IN; g++) begin : g_sync
        pwc_sync #(.STAGES(2)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (raw[g]),
            .q   (sig[g])
        );
    end

    logic                           shdn;
    logic                           word_vld;
    logic [CNT_W-1:0]               word_val;
    logic [NUM_REGS-1:0][CNT_W-1:0] regs;

    pwc_framer #(
        .CNT_W    (CNT_W),
        .GAP_CYC  (GAP_CYC),
        .SHDN_CYC (SHDN_CYC)
    ) u_framer (
        .clk      (clk),
        .rst      (rst),
        .line     (sig[0]),
        .dev_en   (dev_en_o),
        .shdn     (shdn),
        .word_vld (word_vld),
        .word_val (word_val)
    );

    pwc_regfile #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .shdn      (shdn),
        .word_vld  (word_vld),
        .word_val  (word_val),
        .fen_lvl   (sig[1].lvl | sig[2].lvl),
        .fen_start (sig[1].rise | sig[2].rise),
        .regs      (regs),
        .flash_on  (flash_on_o),
        .wr_stb    (wr_stb_o)
    );

    assign flash_lvl_o = regs[IDX_FLASH];
    assign torch_lvl_o = regs[IDX_TORCH];
    assign tmr_dur_o   = regs[IDX_TDUR];
    assign tmr_cur_o   = regs[IDX_TCUR];
    assign lowbat_o    = regs[IDX_LOWBAT];

endmodule

// File: tb/pulse_word_ctrl_test.sv
`timescale 1ns/1ps
module pulse_word_ctrl_test;
    localparam int CW   = 4;
    localparam int GAP  = 16;
    localparam int SHDN = 200;
    localparam int MAXV = (1 << CW) - 1;
    localparam int NV   = 10;
    localparam int VA [NV] = '{1, 2, 3, 4, 5, 6, 2, 7, 5, 3};
    localparam int VD [NV] = '{3, 7, 1, 9, 12, 4, 20, 5, 15, 8};
    localparam int DFLT [5] = '{0, 0, 6, 4, 3};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line = 1'b0;
    logic fa = 1'b0;
    logic fb = 1'b0;
    logic dev_en, flash_on, wr_stb;
    logic [CW-1:0] r_fl, r_to, r_du, r_cu, r_lb;

    int total = 0;
    int fails = 0;
    int stb_cnt = 0;
    int stb_exp = 0;
    int expv [5];
    bit done = 0;

    always #2.5 clk = ~clk;

    pulse_word_ctrl #(.CNT_W(CW), .GAP_CYC(GAP), .SHDN_CYC(SHDN)) uut (
        .clk(clk), .rst(rst), .dc_line_i(line), .fen_a_i(fa), .fen_b_i(fb),
        .dev_en_o(dev_en), .flash_on_o(flash_on), .wr_stb_o(wr_stb),
        .flash_lvl_o(r_fl), .torch_lvl_o(r_to), .tmr_dur_o(r_du),
        .tmr_cur_o(r_cu), .lowbat_o(r_lb)
    );

    always @(posedge clk) if (!rst && wr_stb) stb_cnt <= stb_cnt + 1;

    function automatic int rd(input int i);
        case (i)
            0: return int'(r_fl);
            1: return int'(r_to);
            2: return int'(r_du);
            3: return int'(r_cu);
            default: return int'(r_lb);
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_regs(input string req);
        for (int i = 0; i < 5; i++) chk(req, rd(i), expv[i]);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_word(input int n);
        for (int i = 0; i < n; i++) begin
            line = 1'b0; wait_cyc(3);
            line = 1'b1; wait_cyc(3);
        end
        wait_cyc(GAP + 8);
    endtask

    task automatic send_pair(input int a, input int d);
        send_word(a);
        send_word(d);
        if (a >= 1 && a <= 5) begin
            expv[a-1] = (d > MAXV) ? MAXV : d;
            stb_exp++;
        end
    endtask

    task automatic wake();
        line = 1'b1;
        wait_cyc(GAP + 8);
    endtask

    initial begin
        for (int i = 0; i < 5; i++) expv[i] = DFLT[i];
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(2);

        // R1: reset state
        chk("R1 reset dev_en", int'(dev_en), 0);
        chk("R9 reset flash_on", int'(flash_on), 0);
        chk("R7 reset strobe", int'(wr_stb), 0);
        chk_regs("R1 reset defaults");

        // R1: wake edge enables but is not counted
        wake();
        chk("R1 wake dev_en", int'(dev_en), 1);
        send_pair(2, 5);
        chk("R1 wake edge not counted (torch)", int'(r_to), 5);
        chk("R2 torch after pair", int'(r_to), expv[1]);

        // R2 R4 R5 R6: vector table
        for (int v = 0; v < NV; v++) begin
            send_pair(VA[v], VD[v]);
            chk_regs((VA[v] > 5) ? "R6 bad address ignored" :
                     (VD[v] > MAXV) ? "R4 saturated data" : "R5 register write");
            chk("R7 strobe count", stb_cnt, stb_exp);
        end

        // R3 R8: a 100-cycle low is one pulse, not a shutdown
        line = 1'b0;
        wait_cyc(100);
        chk("R8 short low keeps dev_en", int'(dev_en), 1);
        line = 1'b1;
        wait_cyc(GAP + 8);
        send_word(2);
        expv[0] = 2;
        stb_exp++;
        chk("R3 long low is a single pulse (flash)", int'(r_fl), 2);
        chk_regs("R8 short low keeps registers");
        chk("R7 strobe count after short low", stb_cnt, stb_exp);

        // R9 R10: flash triggers
        send_pair(1, 6);
        fa = 1'b1; wait_cyc(6);
        chk("R9 trigger A starts flash", int'(flash_on), 1);
        fb = 1'b1; wait_cyc(2); fa = 1'b0; wait_cyc(6);
        chk("R10 flash held by trigger B", int'(flash_on), 1);
        chk("R10 flash level kept while B high", int'(r_fl), 6);
        fb = 1'b0; wait_cyc(6);
        expv[0] = 0;
        chk("R10 both low ends flash", int'(flash_on), 0);
        chk("R10 flash level cleared", int'(r_fl), 0);
        fb = 1'b1; wait_cyc(6);
        chk("R9 trigger B starts flash", int'(flash_on), 1);
        fb = 1'b0; wait_cyc(6);

        // R8: shutdown with a half-received pair
        send_word(3);
        line = 1'b0;
        wait_cyc(SHDN + 20);
        for (int i = 0; i < 5; i++) expv[i] = DFLT[i];
        chk("R8 shutdown dev_en", int'(dev_en), 0);
        chk_regs("R8 shutdown defaults");
        wake();
        send_pair(3, 2);
        chk("R8 pending address dropped (duration)", int'(r_du), 2);
        chk_regs("R8 registers after re-wake");
        chk("R7 final strobe count", stb_cnt, stb_exp);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: got 0 expected 1 (run completion)");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule